// File: doc/BRIEF.md
# Hardware Operand Stack Unit

This block is a last-in first-out operand stack for zero-address arithmetic. It keeps its entries in a single-port synchronous memory inside the block and tracks them with a stack pointer register. The pointer always names the next free slot and grows upward from a base address set by parameter. A controller issues one command at a time on a valid/ready port: push a word, pop the top word, or replace the top two words with their sum.

Every command except the reserved code ends with a one-cycle done pulse. For a pop or an add, the value that was read or computed appears on the result bus with that pulse. A push onto a full stack raises an overflow flag. A pop on an empty stack, or an add with fewer than two entries, raises an underflow flag. A failing command changes neither the pointer nor the memory.

The current pointer is brought out so the owner of the stack can see how deep it is. Pops and adds take several cycles. While one is in progress, ready is held low.

Top module: `opstack_unit`

## Requirements
- R1: After reset the pointer equals BASE, ready is 1, and done, overflow, underflow and the result bus are all 0.
- R2: A push (op code 2'b00) accepted with the pointer below BASE+DEPTH stores the data word at the slot the pointer names and advances the pointer by one. The done pulse comes with the accepting clock edge, with no flag set and the result bus unchanged.
- R3: A pop (op code 2'b01) accepted with at least one entry moves the pointer down by one and returns the word at the new pointer. The result and done are visible after the second rising edge, counting the accepting edge as the first. The words come back in the reverse of the order they were pushed.
- R4: A stack-add (op code 2'b10) accepted with at least two entries reads the two top entries and writes their sum, modulo 2^W, into the lower of the two slots. The pointer drops by one, and the sum appears on the result bus with done after the third rising edge, counting the accepting edge as the first.
- R5: Ready is 0 from the edge that accepts a pop or an add until the edge that completes it. A command held valid during that time is not taken.
- R6: A pop with no entries, or an add with fewer than two, produces done with the underflow flag after the accepting edge. The pointer, the memory and the result bus are left unchanged.
- R7: A push while the pointer equals BASE+DEPTH produces done with the overflow flag after the accepting edge. Nothing is written and the pointer stays where it was.
- R8: The reserved op code 2'b11 is accepted and does nothing: no done pulse, no change to the pointer, no change to the stored entries.
- R9: Done, overflow and underflow are one-cycle pulses. Each falls back to 0 on the next edge unless another command completes on that edge. Overflow and underflow are never set together, and neither is set without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is being offered |
| cmd_op | input | 2 | Command: 00 push, 01 pop, 10 add, 11 reserved |
| cmd_data | input | W | Word to push |
| cmd_ready | output | 1 | The unit is able to accept a command |
| done | output | 1 | One-cycle pulse when a command completes |
| res_data | output | W | Word returned by the last pop or add |
| ovf | output | 1 | Overflow pulse, aligned with done |
| unf | output | 1 | Underflow pulse, aligned with done |
| stk_ptr | output | AW | Current stack pointer (next free slot) |

## Verification
The bench aims at the ends of the stack, where off-by-one mistakes hide:
- **Empty and one-entry stacks.** A pop on an empty stack and an add with a single entry must both fail. A design that checked only for "not empty" before an add would read a slot below the base and corrupt the stack.
- **Full stack.** The stack is filled to its exact depth and then pushed once more. A design that tested the limit one slot late would write past the storage and move the pointer out of range.
- **Sum and operand order.** An add whose sum overflows the word checks the modulo result. The pops that follow check that the sum landed in the lower slot and that the operands kept their order.
- **Busy window.** A command is held valid while an add is in progress. A design that let ready through early would take that command and leave an extra word on the stack.

// File: rtl/opstack_unit.sv
module opstack_unit #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int BASE  = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cmd_valid,
  input  logic [1:0]                          cmd_op,
  input  logic [W-1:0]                        cmd_data,
  output logic                                cmd_ready,
  output logic                                done,
  output logic [W-1:0]                        res_data,
  output logic                                ovf,
  output logic                                unf,
  output logic [$clog2(BASE+DEPTH+1)-1:0]     stk_ptr
);

  localparam int AW = $clog2(BASE+DEPTH+1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] SP_BASE = AW'(BASE);
  localparam logic [AW-1:0] SP_TOP  = AW'(BASE + DEPTH);
  localparam logic [1:0] OP_PUSH = 2'b00;
  localparam logic [1:0] OP_POP  = 2'b01;
  localparam logic [1:0] OP_ADD  = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_POP, S_ADD_B, S_ADD_W} st_t;

  st_t            state;
  logic [AW-1:0]  sp;
  logic [W-1:0]   opa;
  logic [W-1:0]   mem [DEPTH];
  logic [W-1:0]   m_rdata;
  logic           m_we, m_re;
  logic [AW-1:0]  m_addr;
  logic [W-1:0]   m_wdata;
  logic [IW-1:0]  m_idx;
  logic [W-1:0]   sum;

  wire accept  = cmd_valid && cmd_ready;
  wire is_push = cmd_op == OP_PUSH;
  wire is_pop  = cmd_op == OP_POP;
  wire is_add  = cmd_op == OP_ADD;
  wire full    = sp == SP_TOP;
  wire empty   = sp == SP_BASE;
  wire lt2     = (sp - SP_BASE) < AW'(2);

  assign cmd_ready = state == S_IDLE;
  assign stk_ptr   = sp;
  assign sum       = opa + m_rdata;
  assign m_idx     = IW'(m_addr - SP_BASE);

  always_comb begin
    m_we    = 1'b0;
    m_re    = 1'b0;
    m_addr  = sp;
    m_wdata = cmd_data;
    case (state)
      S_IDLE: if (accept) begin
        if (is_push && !full) m_we = 1'b1;
        if ((is_pop && !empty) || (is_add && !lt2)) begin
          m_re   = 1'b1;
          m_addr = sp - AW'(1);
        end
      end
      S_ADD_B: begin
        m_re   = 1'b1;
        m_addr = sp - AW'(2);
      end
      S_ADD_W: begin
        m_we    = 1'b1;
        m_addr  = sp - AW'(2);
        m_wdata = sum;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (m_we) mem[m_idx] <= m_wdata;
    else if (m_re) m_rdata <= mem[m_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sp       <= SP_BASE;
      opa      <= '0;
      res_data <= '0;
      done     <= 1'b0;
      ovf      <= 1'b0;
      unf      <= 1'b0;
    end else begin
      done <= 1'b0;
      ovf  <= 1'b0;
      unf  <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (is_push) begin
            done <= 1'b1;
            if (full) ovf <= 1'b1;
            else sp <= sp + AW'(1);
          end else if (is_pop) begin
            if (empty) begin
              done <= 1'b1;
              unf  <= 1'b1;
            end else state <= S_POP;
          end else if (is_add) begin
            if (lt2) begin
              done <= 1'b1;
              unf  <= 1'b1;
            end else state <= S_ADD_B;
          end
        end
        S_POP: begin
          res_data <= m_rdata;
          sp       <= sp - AW'(1);
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        S_ADD_B: begin
          opa   <= m_rdata;
          state <= S_ADD_W;
        end
        S_ADD_W: begin
          res_data <= sum;
          sp       <= sp - AW'(1);
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sp >= SP_BASE && sp <= SP_TOP); // R7
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_push && !full |=> sp == $past(sp) + AW'(1) && done && !ovf); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_push && full |=> $stable(sp) && ovf && done); // R7
  AST_POP_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_pop && empty |=> $stable(sp) && unf && done); // R6
  AST_ADD_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_add && lt2 |=> $stable(sp) && unf && done); // R6
  AST_BUSY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ((is_pop && !empty) || (is_add && !lt2)) |=> !cmd_ready); // R5
  AST_ADD_NET: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_ADD_W |=> sp == $past(sp) - AW'(1) && done); // R4
  AST_FLAG_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf || unf) |-> done && !(ovf && unf)); // R9
  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_op == 2'b11 |=> !done && $stable(sp)); // R8

endmodule

// File: tb/opstack_unit_bench.sv
`timescale 1ns/1ps
module opstack_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [15:0] cmd_data = '0;
  logic        cmd_ready, done, ovf, unf;
  logic [15:0] res_data;
  logic [4:0]  stk_ptr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  opstack_unit #(.W(16), .DEPTH(8), .BASE(16)) u_opstack_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_ready(cmd_ready), .done(done),
    .res_data(res_data), .ovf(ovf), .unf(unf), .stk_ptr(stk_ptr));

  // row: op[40:39] data[38:23] sp_after[22:18] result[17:2] unf[1] ovf[0]
  localparam int NV = 27;
  localparam logic [40:0] VEC [NV] = '{
    {2'd1, 16'h0000, 5'd16, 16'h0000, 1'b1, 1'b0},
    {2'd0, 16'h1111, 5'd17, 16'h0000, 1'b0, 1'b0},
    {2'd2, 16'h0000, 5'd17, 16'h0000, 1'b1, 1'b0},
    {2'd0, 16'h2222, 5'd18, 16'h0000, 1'b0, 1'b0},
    {2'd0, 16'hF000, 5'd19, 16'h0000, 1'b0, 1'b0},
    {2'd2, 16'h0000, 5'd18, 16'h1222, 1'b0, 1'b0},
    {2'd1, 16'h0000, 5'd17, 16'h1222, 1'b0, 1'b0},
    {2'd1, 16'h0000, 5'd16, 16'h1111, 1'b0, 1'b0},
    {2'd1, 16'h0000, 5'd16, 16'h1111, 1'b1, 1'b0},
    {2'd0, 16'h0A01, 5'd17, 16'h0000, 1'b0, 1'b0},
    {2'd0, 16'h0A02, 5'd18, 16'h0000, 1'b0, 1'b0},
    {2'd0, 16'h0A03, 5'd19, 16'h0000, 1'b0, 1'b0},
    {2'd0, 16'h0A04, 5'd20, 16'h0000, 1'b0, 1'b0},
    {2'd0, 16'h0A05, 5'd21, 16'h0000, 1'b0, 1'b0},
    {2'd0, 16'h0A06, 5'd22, 16'h0000, 1'b0, 1'b0},
    {2'd0, 16'h0A07, 5'd23, 16'h0000, 1'b0, 1'b0},
    {2'd0, 16'h0A08, 5'd24, 16'h0000, 1'b0, 1'b0},
    {2'd0, 16'hBEEF, 5'd24, 16'h0000, 1'b0, 1'b1},
    {2'd1, 16'h0000, 5'd23, 16'h0A08, 1'b0, 1'b0},
    {2'd2, 16'h0000, 5'd22, 16'h140D, 1'b0, 1'b0},
    {2'd2, 16'h0000, 5'd21, 16'h1E12, 1'b0, 1'b0},
    {2'd1, 16'h0000, 5'd20, 16'h1E12, 1'b0, 1'b0},
    {2'd0, 16'hFFFF, 5'd21, 16'h0000, 1'b0, 1'b0},
    {2'd0, 16'h0001, 5'd22, 16'h0000, 1'b0, 1'b0},
    {2'd2, 16'h0000, 5'd21, 16'h0000, 1'b0, 1'b0},
    {2'd1, 16'h0000, 5'd20, 16'h0000, 1'b0, 1'b0},
    {2'd1, 16'h0000, 5'd19, 16'h0A04, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [15:0] d, output int lat);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat, exp_lat;
    repeat (3) @(negedge clk);
    chk("R1 sp", stk_ptr, 16);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 done", done, 0);
    chk("R1 flags", {ovf, unf}, 0);
    chk("R1 result", res_data, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][40:39];
      run_cmd(op, VEC[i][38:23], lat);
      if (VEC[i][1] || VEC[i][0] || op == 2'd0) exp_lat = 1;
      else if (op == 2'd1) exp_lat = 2;
      else exp_lat = 3;
      // R2 push, R3 pop, R4 add, R6 underflow, R7 overflow
      chk($sformatf("R2/R3/R4 latency row %0d", i), lat, exp_lat);
      chk($sformatf("R6 underflow row %0d", i), unf, VEC[i][1]);
      chk($sformatf("R7 overflow row %0d", i), ovf, VEC[i][0]);
      chk($sformatf("R3 R4 pointer row %0d", i), stk_ptr, VEC[i][22:18]);
      if (op != 2'd0)
        chk($sformatf("R3 R4 result row %0d", i), res_data, VEC[i][17:2]);
      @(negedge clk);
      chk($sformatf("R9 done pulse row %0d", i), {done, ovf, unf}, 0);
    end

    // R5: hold a push valid during an add; it must not be taken
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2;
    @(posedge clk);
    @(negedge clk);
    cmd_op = 2'd0; cmd_data = 16'h7777;
    chk("R5 ready low cycle 1", cmd_ready, 0);
    @(negedge clk);
    chk("R5 ready low cycle 2", cmd_ready, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R4 add done", done, 1);
    chk("R4 add sum", res_data, 16'h1405);
    chk("R4 add pointer", stk_ptr, 18);
    @(negedge clk);
    chk("R5 no stray push", stk_ptr, 18);
    run_cmd(2'd1, 16'h0, lat);
    chk("R5 top after busy", res_data, 16'h1405);
    chk("R5 pointer after pop", stk_ptr, 17);

    // R8: reserved op does nothing
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_data = 16'h5555;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 no done", done, 0);
    chk("R8 pointer", stk_ptr, 17);
    @(negedge clk);
    chk("R8 still no done", done, 0);
    run_cmd(2'd1, 16'h0, lat);
    chk("R8 entry intact", res_data, 16'h0A01);
    chk("R3 drained to base", stk_ptr, 16);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule